// File: doc/BRIEF.md
# Dual-Match Down-Counter Timer Channel

This block is a single timer channel. A 32-bit count is loaded from a reload value when the channel is enabled. It then decrements once per tick. A clock-select input picks the tick source: every system clock cycle, or only the cycles on which an external 1 MHz tick-enable strobe is high. When the count reaches zero, the next tick loads the reload value again and counting carries on.

Two match values and the zero crossing produce interrupt events. Each event inverts the level of the interrupt output; it is not a pulse. A front end, outside this block, decodes addresses. It drives register writes through a select code and a data word, supplies the control levels, and reads values back through a combinational read port.

Top module: `dual_match_timer`

## Requirements
- R1: Reset drives `irq_o` low and clears the reload value and both match values. The timer comes out of reset disabled. The read select codes are: 0 = count, 1 = reload, 2 = match A, 3 = match B. The write select uses the same codes. After reset all four reads return 0.
- R2: On the first clock with `en_i` high after a clock with it low, the count loads the reload value. After that it decrements by one on each tick. With `clk_sel_i`=0 every clock is a tick. With `clk_sel_i`=1 only clocks with `ext_tick_i` high are ticks.
- R3: While `en_i` is low, the count does not change and `irq_o` does not change. A read with select 0 returns the reload value.
- R4: A tick taken while the count is zero loads the reload value. No event comes from this tick.
- R5: The effective value of a match register is the register itself when it is below the reload value, and zero otherwise.
- R6: A tick that moves the count to a nonzero value equal to either effective match value inverts `irq_o`.
- R7: A tick that moves the count to zero inverts `irq_o` when either of these holds: `wrap_irq_en_i` is high, or either effective match value is zero.
- R8: A tick inverts `irq_o` at most once, even when several event conditions hold on it.
- R9: A count write (select 0) while enabled replaces the count. The written value then keeps counting down from there. A count write while disabled does not change the value loaded at the next enable.
- R10: A reload write while enabled starts counting from the written value if the old reload was zero and the new value is nonzero. Otherwise a reload write leaves the running count alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Channel enable level |
| clk_sel_i | input | 1 | Tick source: 0 every clock, 1 external tick strobe |
| ext_tick_i | input | 1 | External 1 MHz tick-enable strobe |
| wrap_irq_en_i | input | 1 | Enables the event on reaching zero |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 count, 1 reload, 2 match A, 3 match B |
| wr_data_i | input | W | Write data |
| rd_sel_i | input | 2 | Read target, same codes as write |
| rd_data_o | output | W | Read data (combinational) |
| irq_o | output | 1 | Interrupt level, inverted on each event |

## Verification
The bench builds the block with the default width of 32. Reload values stay small, from 0 to 10, so each full countdown lasts only a handful of clocks. That makes it possible to count the interrupt inversions over exactly one period for many match and wrap combinations. These include matches at or above the reload value, matches of zero, and two equal matches. Directed sequences with the external tick source keep the count still between strobes. This exposes count overwrite, restart from a zero reload and readback of the reload value while disabled.

// File: rtl/dual_match_timer.sv
module dual_match_timer #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         clk_sel_i,
  input  logic         ext_tick_i,
  input  logic         wrap_irq_en_i,
  input  logic         wr_en_i,
  input  logic [1:0]   wr_sel_i,
  input  logic [W-1:0] wr_data_i,
  input  logic [1:0]   rd_sel_i,
  output logic [W-1:0] rd_data_o,
  output logic         irq_o
);

  localparam logic [1:0] SEL_CNT = 2'd0;
  localparam logic [1:0] SEL_RLD = 2'd1;
  localparam logic [1:0] SEL_MA  = 2'd2;
  localparam logic [1:0] SEL_MB  = 2'd3;

  logic [W-1:0] cnt, reload, match_a, match_b;
  logic         en_q;

  wire start = en_i & ~en_q;
  wire tick  = en_i & ~start & (clk_sel_i ? ext_tick_i : 1'b1);

  wire wr_cnt = wr_en_i & en_i & ~start & (wr_sel_i == SEL_CNT);
  wire wr_kick = wr_en_i & en_i & ~start & (wr_sel_i == SEL_RLD)
               & (reload == '0) & (wr_data_i != '0);
  wire cnt_wr = wr_cnt | wr_kick;

  wire [W-1:0] nxt   = cnt - 1'b1;
  wire [W-1:0] eff_a = (match_a < reload) ? match_a : '0;
  wire [W-1:0] eff_b = (match_b < reload) ? match_b : '0;

  wire hit_match = (nxt != '0) & ((nxt == eff_a) | (nxt == eff_b));
  wire hit_zero  = (nxt == '0) & (wrap_irq_en_i | (eff_a == '0) | (eff_b == '0));
  wire event_now = tick & ~cnt_wr & (cnt != '0) & (hit_match | hit_zero);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      cnt     <= '0;
      reload  <= '0;
      match_a <= '0;
      match_b <= '0;
      irq_o   <= 1'b0;
    end else begin
      en_q <= en_i;
      if (wr_en_i) begin
        case (wr_sel_i)
          SEL_RLD: reload  <= wr_data_i;
          SEL_MA:  match_a <= wr_data_i;
          SEL_MB:  match_b <= wr_data_i;
          default: ;
        endcase
      end
      if (start)                cnt <= reload;
      else if (cnt_wr)          cnt <= wr_data_i;
      else if (tick)            cnt <= (cnt == '0) ? reload : nxt;
      if (event_now)            irq_o <= ~irq_o;
    end
  end

  always_comb begin
    case (rd_sel_i)
      SEL_CNT: rd_data_o = en_i ? cnt : reload;
      SEL_RLD: rd_data_o = reload;
      SEL_MA:  rd_data_o = match_a;
      default: rd_data_o = match_b;
    endcase
  end

  // R1: reset leaves the interrupt low and the reload cleared
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (!irq_o && reload == '0));

  // R2: enabling loads the reload value
  a_r2_start_load: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> cnt == $past(reload));

  // R2: a tick decrements a nonzero count
  a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && cnt != '0) |=> cnt == $past(cnt) - 1'b1);

  // R3: disabled channel holds its count
  a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(cnt));

  // R3: the interrupt only moves while enabled
  a_r3_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o != $past(irq_o)) |-> $past(en_i));

  // R4: a tick at zero reloads
  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && cnt == '0) |=> cnt == $past(reload));

  // R9: a count write while running takes effect
  a_r9_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> cnt == $past(wr_data_i));

endmodule

// File: tb/dual_match_timer_tb.sv
module dual_match_timer_tb;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, clk_sel = 1'b0, ext_tick = 1'b0, wrap_en = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0, rd_sel = '0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic irq;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_match_timer #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .clk_sel_i(clk_sel),
    .ext_tick_i(ext_tick), .wrap_irq_en_i(wrap_en), .wr_en_i(wr_en),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .rd_sel_i(rd_sel),
    .rd_data_o(rd_data), .irq_o(irq)
  );

  // reload, match A, match B, wrap enable, expected toggles per period
  localparam int NV = 10;
  localparam int VEC [NV][5] = '{
    '{10, 3, 7, 0, 2},
    '{10, 3, 7, 1, 3},
    '{10, 0, 5, 0, 2},
    '{10, 12, 5, 0, 2},
    '{10, 4, 4, 0, 1},
    '{10, 4, 4, 1, 2},
    '{8, 10, 20, 0, 1},
    '{6, 1, 6, 0, 2},
    '{5, 2, 3, 0, 2},
    '{7, 7, 2, 0, 2}
  };

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [W-1:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] sel, output logic [W-1:0] v);
    rd_sel = sel; #1; v = rd_data;
  endtask

  task automatic tick_ext(int n);
    for (int i = 0; i < n; i++) begin
      ext_tick = 1'b1; @(negedge clk); ext_tick = 1'b0; @(negedge clk);
    end
  endtask

  initial begin
    logic [W-1:0] v;
    logic prev;
    int tog;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 irq", {31'd0, irq}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int s = 0; s < 4; s++) begin
      rd(s[1:0], v); check("R1 readback", v, 0);
    end

    // Table: toggles over one full period (R5 R6 R7 R8)
    for (int k = 0; k < NV; k++) begin
      wr(2'd1, VEC[k][0]); wr(2'd2, VEC[k][1]); wr(2'd3, VEC[k][2]);
      wrap_en = VEC[k][3][0]; clk_sel = 1'b0;
      en = 1'b1; prev = irq; tog = 0;
      for (int c = 0; c < VEC[k][0] + 2; c++) begin
        @(negedge clk);
        if (irq !== prev) tog++;
        prev = irq;
      end
      en = 1'b0;
      check("R6/R7/R8 toggles (R5 effective match)", tog, VEC[k][4]);
    end

    // R1 readback of match registers
    rd(2'd2, v); check("R1 match A read", v, 7);
    rd(2'd3, v); check("R1 match B read", v, 2);

    // R2: external tick source
    wrap_en = 1'b0; wr(2'd2, 0); wr(2'd3, 0);
    wr(2'd1, 5); clk_sel = 1'b1; en = 1'b1;
    repeat (4) @(negedge clk);
    rd(2'd0, v); check("R2 no strobe holds count", v, 5);
    tick_ext(2);
    rd(2'd0, v); check("R2 ext ticks decrement", v, 3);

    // R3: disabled read returns reload, irq still
    en = 1'b0; prev = irq;
    clk_sel = 1'b0; repeat (12) @(negedge clk);
    rd(2'd0, v); check("R3 disabled reads reload", v, 5);
    check("R3 irq still", {31'd0, irq}, {31'd0, prev});

    // R4: wrap to reload, every clock tick
    wr(2'd1, 3); en = 1'b1;
    repeat (5) @(negedge clk);
    rd(2'd0, v); check("R4 reload after zero", v, 3);

    // R9: overwrite while enabled
    clk_sel = 1'b1;
    wr(2'd0, 2);
    rd(2'd0, v); check("R9 count overwrite", v, 2);
    tick_ext(1);
    rd(2'd0, v); check("R9 counts from written", v, 1);
    en = 1'b0; @(negedge clk);
    wr(2'd0, 9);
    en = 1'b1; @(negedge clk);
    rd(2'd0, v); check("R9 disabled write ignored", v, 3);

    // R10: reload from zero kicks off counting
    en = 1'b0; wr(2'd1, 0); en = 1'b1; @(negedge clk);
    rd(2'd0, v); check("R10 zero reload count", v, 0);
    wr(2'd1, 7);
    rd(2'd0, v); check("R10 start from new reload", v, 7);
    wr(2'd1, 3);
    rd(2'd0, v); check("R10 running count kept", v, 7);
    rd(2'd1, v); check("R10 reload updated", v, 3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule